// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and a 32K x 8 asynchronous static RAM. The host hands over one access at a time on a valid/ready port: a 15-bit address, a read/write flag and, for writes, a byte of data. The controller then drives the RAM's active-low chip select, output enable and write strobe through a fixed sequence of phases. Each phase lasts long enough to meet the part's minimum timings. Read data returns to the host as a registered byte with a one-cycle valid pulse.

The length of every phase is a whole number of clocks. It is computed at elaboration time from a clock-period parameter and from nanosecond limits. Each limit is divided by the period, rounded up, and given a floor of one cycle. The defaults are the faster speed grade at 8 ns: a 9-cycle read, an 8-cycle write strobe, a 9-cycle write cycle and a 4-cycle bus turnaround.

Writes are strobed by the write enable. Output enable stays high for the whole write, so the RAM never drives the bus while the controller does. The bidirectional data pins are split into an output byte, an output-enable and an input byte, and a tristate pad joins them at the chip edge.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the chip select, output enable and write strobe outputs are high (1), the data drive enable is 0, `req_ready` is 1 and `rsp_valid` is 0. An asserted reset returns a write in progress to this state.
- R2: A read is accepted on a clock edge where `req_valid` and `req_ready` are both 1 and `req_write` is 0. From the next cycle, `sram_ce_n` and `sram_oe_n` are 0 and `sram_we_n` is 1 for exactly RD_CYC cycles, which is 9 at the defaults. During those cycles `sram_addr` equals the request address.
- R3: The byte on `sram_dq_i` in the last read cycle is returned on `rsp_rdata`. That byte is captured during the read strobe. Next, select and output enable go high for TA_CYC cycles (4) with the bus released. Then `rsp_valid` pulses for exactly one cycle, in the same cycle that `req_ready` returns to 1. At the defaults `req_ready` is next seen 14 cycles after the accept edge.
- R4: A write is accepted when `req_write` is 1. `sram_we_n` is then 0 for exactly WP_CYC cycles, which is 8 at the defaults and is the largest of the strobe-width, address-to-end and data-setup limits. `sram_ce_n` is 0 and `sram_oe_n` stays 1 for the whole write.
- R5: The write data is driven (`sram_dq_oe` = 1) from the cycle the strobe falls until one cycle after it rises. That is 9 cycles at the defaults. `sram_dq_o` and `sram_addr` hold the request's data and address during every strobe-low cycle.
- R6: A write cycle occupies WC_CYC cycles (9) before `req_ready` returns. WC_CYC is at least one cycle longer than the strobe, and at the defaults `req_ready` is next seen 10 cycles after the accept edge. No bus turnaround follows a write.
- R7: While `req_ready` is 0, `req_valid` and the request fields are ignored. A request presented then does not lower the write strobe, does not change `sram_addr` and does not alter the read data returned.
- R8: With no request pending, all three strobes stay high and the data bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse: read byte available |
| rsp_rdata | output | 8 | Read byte |
| sram_addr | output | 15 | RAM address pins |
| sram_dq_o | output | 8 | Byte driven toward the RAM |
| sram_dq_oe | output | 1 | Pad drive enable for sram_dq_o |
| sram_dq_i | input | 8 | Byte received from the RAM |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |

## Verification
The bench counts the exact strobe widths of reads and writes, since an off-by-one in rounding or in the counter load would shorten a strobe below the part's minimum. It checks that output enable never falls while the write strobe is low and that the bus is driven one cycle past the strobe. A design that got either wrong would fight the RAM's drivers or break the data hold. It also holds a conflicting write request on the port during a read, which catches a controller that restarts mid-cycle. Finally, it checks that the read byte and its valid pulse line up with the return of ready only after the turnaround gap.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_TURN,
        PH_WSTROBE,
        PH_WRECOV
    } phase_e;

    // nanoseconds to clock cycles, rounded up, never below one
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW       = 15,
    parameter int DW       = 8,
    parameter int CLK_NS   = 8,
    parameter int T_RC_NS  = 70,
    parameter int T_AA_NS  = 70,
    parameter int T_OE_NS  = 35,
    parameter int T_OHZ_NS = 30,
    parameter int T_WC_NS  = 70,
    parameter int T_WP_NS  = 55,
    parameter int T_AW_NS  = 60,
    parameter int T_DW_NS  = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_dq_o,
    output logic          sram_dq_oe,
    input  logic [DW-1:0] sram_dq_i,
    output logic          sram_ce_n,
    output logic          sram_oe_n,
    output logic          sram_we_n
);
    // phase lengths in cycles
    localparam int RD_CYC  = imax(ns_to_cyc(T_RC_NS, CLK_NS),
                             imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)));
    localparam int TA_CYC  = ns_to_cyc(T_OHZ_NS, CLK_NS);
    localparam int WP_CYC  = imax(ns_to_cyc(T_WP_NS, CLK_NS),
                             imax(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)));
    localparam int WC_CYC  = imax(ns_to_cyc(T_WC_NS, CLK_NS), WP_CYC + 1);
    localparam int REC_CYC = WC_CYC - WP_CYC;
    localparam int MAX_CYC = imax(imax(RD_CYC, TA_CYC), imax(WP_CYC, REC_CYC));
    localparam int CW      = $clog2(MAX_CYC + 1);

    typedef struct packed {
        phase_e        ph;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          rvld;
        logic          ce_n;
        logic          oe_n;
        logic          we_n;
        logic          dq_en;
    } ctl_s;

    localparam ctl_s CTL_RST = '{ph: PH_IDLE, addr: '0, wdata: '0, rdata: '0,
                                 rvld: 1'b0, ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                 dq_en: 1'b0};

    ctl_s          ctl_d, ctl_q;
    logic          ph_load;
    logic [CW-1:0] ph_len;
    logic          ph_last;

    sram_phase_cnt #(.CW(CW)) u_phase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_len),
        .last     (ph_last)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rvld = 1'b0;
        ph_load    = 1'b0;
        ph_len     = '0;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr = req_addr;
                    ctl_d.ce_n = 1'b0;
                    ph_load    = 1'b1;
                    if (req_write) begin
                        ctl_d.ph    = PH_WSTROBE;
                        ctl_d.we_n  = 1'b0;
                        ctl_d.dq_en = 1'b1;
                        ctl_d.wdata = req_wdata;
                        ph_len      = CW'(WP_CYC - 1);
                    end else begin
                        ctl_d.ph   = PH_READ;
                        ctl_d.oe_n = 1'b0;
                        ph_len     = CW'(RD_CYC - 1);
                    end
                end
            end
            PH_READ: begin
                if (ph_last) begin
                    ctl_d.rdata = sram_dq_i;
                    ctl_d.ce_n  = 1'b1;
                    ctl_d.oe_n  = 1'b1;
                    ctl_d.ph    = PH_TURN;
                    ph_load     = 1'b1;
                    ph_len      = CW'(TA_CYC - 1);
                end
            end
            PH_TURN: begin
                if (ph_last) begin
                    ctl_d.ph   = PH_IDLE;
                    ctl_d.rvld = 1'b1;
                end
            end
            PH_WSTROBE: begin
                if (ph_last) begin
                    ctl_d.we_n = 1'b1;
                    ctl_d.ph   = PH_WRECOV;
                    ph_load    = 1'b1;
                    ph_len     = CW'(REC_CYC - 1);
                end
            end
            PH_WRECOV: begin
                if (ph_last) begin
                    ctl_d.ce_n  = 1'b1;
                    ctl_d.dq_en = 1'b0;
                    ctl_d.ph    = PH_IDLE;
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign req_ready  = (ctl_q.ph == PH_IDLE);
    assign rsp_valid  = ctl_q.rvld;
    assign rsp_rdata  = ctl_q.rdata;
    assign sram_addr  = ctl_q.addr;
    assign sram_dq_o  = ctl_q.wdata;
    assign sram_dq_oe = ctl_q.dq_en;
    assign sram_ce_n  = ctl_q.ce_n;
    assign sram_oe_n  = ctl_q.oe_n;
    assign sram_we_n  = ctl_q.we_n;

    // ---------------- assertions ----------------
    logic [CW:0] we_run_q, rd_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run_q <= '0;
            rd_run_q <= '0;
        end else begin
            we_run_q <= !sram_we_n ? we_run_q + 1'b1 : '0;
            rd_run_q <= (!sram_ce_n && !sram_oe_n) ? rd_run_q + 1'b1 : '0;
        end
    end

    a_r4_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_oe_n && !sram_ce_n));

    a_r4_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_run_q == (CW+1)'(WP_CYC)));

    a_r2_read_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> (rd_run_q == (CW+1)'(RD_CYC)));

    a_r5_drive_past_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> sram_dq_oe);

    a_r5_no_drive_when_reading: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    a_r5_stable_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && $past(!sram_we_n)) |-> ($stable(sram_dq_o) && $stable(sram_addr)));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (req_ready ##1 !rsp_valid));

    a_r7_busy_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> !req_ready);

endmodule

// File: tb/sram_cycle_ctrl_tb_top.sv
module sram_cycle_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [14:0] sram_addr;
    logic [7:0]  sram_dq_o;
    logic        sram_dq_oe;
    logic [7:0]  sram_dq_i;
    logic        sram_ce_n, sram_oe_n, sram_we_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    sram_cycle_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
        .sram_dq_i(sram_dq_i),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
    );

    function automatic logic [7:0] ram_pat(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    // RAM model: outputs a byte only in the read mode
    assign sram_dq_i = (!sram_ce_n && !sram_oe_n && sram_we_n) ? ram_pat(sram_addr) : 8'h00;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [14:0] a;
        logic [7:0]  d;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 15'h0000, 8'h11},
        '{1'b0, 15'h7FFF, 8'h00},
        '{1'b1, 15'h7FFF, 8'hFF},
        '{1'b0, 15'h0000, 8'h00},
        '{1'b1, 15'h1234, 8'hA5},
        '{1'b1, 15'h4321, 8'h3C},
        '{1'b0, 15'h1234, 8'h00},
        '{1'b0, 15'h5555, 8'h00}
    };

    task automatic run_op(input logic wr, input logic [14:0] a, input logic [7:0] d,
                          input bit noise);
        int n = 1, rd_lo = 0, we_lo = 0, drv = 0, oe_bad = 0, dat_bad = 0;
        int addr_bad = 0, vpulse = 0, busy_vld = 0;
        logic [7:0] got = 8'h00;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        if (noise) begin
            req_write = 1'b1; req_addr = ~a; req_wdata = ~d;
        end else begin
            req_valid = 1'b0;
        end
        forever begin
            if (!sram_ce_n && !sram_oe_n) rd_lo++;
            if (!sram_we_n) begin
                we_lo++;
                if (!sram_oe_n) oe_bad++;
                if (sram_dq_o != d || sram_addr != a) dat_bad++;
            end
            if (sram_dq_oe) drv++;
            if (!sram_ce_n && sram_addr != a) addr_bad++;
            if (rsp_valid) begin
                vpulse++;
                got = rsp_rdata;
                if (!req_ready) busy_vld++;
            end
            if (req_ready || n > 60) break;
            if (noise && n == 5) req_valid = 1'b0;
            n++;
            @(negedge clk);
        end
        chk("R2/R4 address held while selected", addr_bad, 0);
        if (wr) begin
            chk("R4 strobe-low cycles", we_lo, 8);
            chk("R4 output enable low during strobe", oe_bad, 0);
            chk("R5 drive-enable cycles", drv, 9);
            chk("R5 data/address mismatches in strobe", dat_bad, 0);
            chk("R6 cycles to ready after write", n, 10);
            chk("R6 no read pulse after write", vpulse, 0);
        end else begin
            chk("R2 read-select cycles", rd_lo, 9);
            chk(noise ? "R7 strobe stayed high under busy request" : "R2 strobe high in read",
                we_lo, 0);
            chk("R3 cycles to ready after read", n, 14);
            chk("R3 one valid pulse", vpulse, 1);
            chk("R3 valid only with ready", busy_vld, 0);
            chk("R3 read byte", int'(got), int'(ram_pat(a)));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 ce_n in reset", int'(sram_ce_n), 1);
        chk("R1 oe_n in reset", int'(sram_oe_n), 1);
        chk("R1 we_n in reset", int'(sram_we_n), 1);
        chk("R1 drive in reset", int'(sram_dq_oe), 0);
        chk("R1 ready in reset", int'(req_ready), 1);
        chk("R1 valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", int'(req_ready), 1);

        // R8: idle with no request
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R8 idle strobes high", int'({sram_ce_n, sram_oe_n, sram_we_n}), 7);
            chk("R8 idle bus released", int'(sram_dq_oe), 0);
        end

        // vector table
        for (int i = 0; i < 8; i++)
            run_op(VECS[i].wr, VECS[i].a, VECS[i].d, 1'b0);

        // R7: conflicting write request held during a read
        run_op(1'b0, 15'h2AAA, 8'h00, 1'b1);
        @(negedge clk);
        chk("R7 nothing started after busy request", int'(sram_ce_n), 1);

        // R1: reset in the middle of a write
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0F0F; req_wdata = 8'h77;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4 strobe low before reset", int'(sram_we_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 strobes high after mid-write reset",
            int'({sram_ce_n, sram_oe_n, sram_we_n}), 7);
        chk("R1 bus released after mid-write reset", int'(sram_dq_oe), 0);
        chk("R1 ready after mid-write reset", int'(req_ready), 1);
        rst_n = 1'b1;
        run_op(1'b0, 15'h0F0F, 8'h00, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule